// File: doc/BRIEF.md
# UART Automatic Baud Rate Detector

This block watches the receive line of a UART and works out the bit period of the far end from the first character it receives. Once armed, it waits for the falling edge of a start bit. It then counts system clock cycles until a chosen closing edge. The count becomes a baud divisor, expressed in system clock cycles per bit, which the rest of the receiver can load once the done pulse appears.

The block has two measuring methods, picked by a one-bit mode input that is captured when the block is armed. In the short method the closing edge is the rising edge at the end of the start bit. The sender's first data bit must therefore be 1. In the long method the closing edge is the next falling edge, which spans the start bit and the first data bit. The character must then begin with data bits 1 then 0. This method is less sensitive to slow or asymmetric edges. Counts that are too short or that saturate the counter are reported as errors, and no divisor is produced for them. While a measurement is open, a busy output tells the receiver to drop the current character.

Top module: `uart_baud_detect`

## Requirements
- R1: During and right after reset, `busy_o`, `done_o` and `err_o` are low and `divisor_o` is zero.
- R2: With mode 0 captured (mode_i = 0 at arm), the divisor equals the number of clock cycles the line stays low from the start-bit falling edge to the next rising edge.
- R3: With mode 1 captured (mode_i = 1 at arm), the count N runs from the start-bit falling edge to the next falling edge. The divisor is (N + 1) >> 1, which is N halved and rounded by the dropped bit.
- R4: The mode is taken from `mode_i` in the cycle `arm_i` is accepted. Changes on `mode_i` during a measurement do not alter the result.
- R5: A measured count below 16 cycles gives a one-cycle `err_o` pulse, no `done_o`, and leaves `divisor_o` unchanged.
- R6: If the count reaches 2^CNT_W - 1 (4095 by default) before the closing edge, the block gives a one-cycle `err_o` pulse, no `done_o`, and leaves `divisor_o` unchanged. A count of 2^CNT_W - 2 is still valid.
- R7: `done_o` and `err_o` are single-cycle pulses that are never high together. Exactly one of them ends each armed measurement. Afterwards the block stays idle and ignores line edges until it is armed again.
- R8: `busy_o` goes high the cycle after an accepted arm and stays high until the cycle that `done_o` or `err_o` pulses. An `arm_i` pulse while busy is ignored.
- R9: `divisor_o` changes only in a cycle in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | One-cycle request to start a detection |
| mode_i | input | 1 | Measuring method: 0 = start bit only, 1 = start bit plus first data bit |
| rx_i | input | 1 | Asynchronous serial receive line, idle high |
| busy_o | output | 1 | Detection in progress; current character is to be ignored |
| done_o | output | 1 | One-cycle pulse: a valid divisor was produced |
| err_o | output | 1 | One-cycle pulse: measurement out of range |
| divisor_o | output | CNT_W | Clock cycles per bit from the last good measurement |

## Verification
Random characters with independent start-bit and first-data-bit lengths are sent in both modes. Unequal lengths show whether mode 0 closes on the rising edge and mode 1 on the following falling edge. Odd sums in mode 1 check the rounding bit. Directed patterns sit on each side of the 16-cycle floor and the 4095-cycle ceiling, which separates valid counts from errors. Other runs toggle `mode_i` and pulse `arm_i` in the middle of a measurement, which shows whether the captured mode and the ignore-while-busy rule hold. The extra edges that follow every character show whether the block really stays idle after a result.

// File: rtl/abd_pkg.sv
package abd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMED   = 2'd1,
    ST_MEASURE = 2'd2
  } abd_state_e;

  typedef enum logic {
    MODE_START_ONLY = 1'b0,
    MODE_TWO_BITS   = 1'b1
  } abd_mode_e;
endpackage

// File: rtl/abd_edge_sync.sv
module abd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b1;
          else         sync_q[0] <= rx_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b1;
          else         sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/abd_cycle_counter.sv
module abd_cycle_counter #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o,
  output logic         at_max_o
);
  localparam logic [W-1:0] CntMax = {W{1'b1}};
  localparam logic [W-1:0] CntOne = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign at_max_o = (cnt_q == CntMax);
  assign cnt_en   = load_i | (inc_i & ~at_max_o);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = CntOne;
    else if (inc_i) cnt_d = cnt_q + CntOne;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/abd_divisor_calc.sv
module abd_divisor_calc #(
  parameter int W = 12
) (
  input  logic [W-1:0] count_i,
  input  logic         two_bits_i,
  output logic [W-1:0] divisor_o
);
  logic [W-1:0] half_rounded;

  assign half_rounded = {1'b0, count_i[W-1:1]} + {{(W-1){1'b0}}, count_i[0]};
  assign divisor_o    = two_bits_i ? half_rounded : count_i;
endmodule

// File: rtl/uart_baud_detect.sv
module uart_baud_detect
  import abd_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int MIN_CNT     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             mode_i,
  input  logic             rx_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [CNT_W-1:0] divisor_o
);
  localparam logic [CNT_W-1:0] MinCount = CNT_W'(MIN_CNT);

  abd_state_e       state_q, state_d;
  abd_mode_e        mode_q, mode_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic [CNT_W-1:0] div_q, div_d;
  logic             div_en;

  logic             line_rise, line_fall, close_edge;
  logic             cnt_load, cnt_inc, cnt_at_max;
  logic [CNT_W-1:0] cnt_val, div_calc;

  abd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .rise_o (line_rise),
    .fall_o (line_fall)
  );

  abd_cycle_counter #(.W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (cnt_load),
    .inc_i    (cnt_inc),
    .count_o  (cnt_val),
    .at_max_o (cnt_at_max)
  );

  abd_divisor_calc #(.W(CNT_W)) u_calc (
    .count_i    (cnt_val),
    .two_bits_i (mode_q == MODE_TWO_BITS),
    .divisor_o  (div_calc)
  );

  assign close_edge = (mode_q == MODE_TWO_BITS) ? line_fall : line_rise;

  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    div_d    = div_q;
    div_en   = 1'b0;
    cnt_load = 1'b0;
    cnt_inc  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (arm_i) begin
          state_d = ST_ARMED;
          mode_d  = abd_mode_e'(mode_i);
        end
      end
      ST_ARMED: begin
        if (line_fall) begin
          state_d  = ST_MEASURE;
          cnt_load = 1'b1;
        end
      end
      ST_MEASURE: begin
        if (cnt_at_max) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end else if (close_edge) begin
          state_d = ST_IDLE;
          if (cnt_val < MinCount) begin
            err_d = 1'b1;
          end else begin
            done_d = 1'b1;
            div_d  = div_calc;
            div_en = 1'b1;
          end
        end else begin
          cnt_inc = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_START_ONLY;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (div_en) div_q <= div_d;
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign divisor_o = div_q;
endmodule

// File: rtl/uart_baud_detect_checker.sv
module uart_baud_detect_checker #(
  parameter int CNT_W   = 12,
  parameter int MIN_CNT = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             arm_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic [CNT_W-1:0] divisor_o,
  input logic             mode_q
);
  localparam logic [CNT_W-1:0] HalfMin = CNT_W'(MIN_CNT / 2);

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |=> (!busy_o && !done_o && !err_o && divisor_o == '0));

  a_r7_no_double_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  a_r8_idle_on_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> !busy_o);

  a_r8_arm_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !busy_o) |=> busy_o);

  a_r4_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mode_q));

  a_r9_div_only_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(divisor_o));

  a_r5_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (divisor_o >= HalfMin));
endmodule

bind uart_baud_detect uart_baud_detect_checker #(
  .CNT_W   (CNT_W),
  .MIN_CNT (MIN_CNT)
) u_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .arm_i     (arm_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .divisor_o (divisor_o),
  .mode_q    (mode_q)
);

// File: tb/uart_baud_detect_tb.sv
module uart_baud_detect_tb;
  localparam int CW   = 12;
  localparam int CMAX = (1 << CW) - 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic arm_i = 1'b0;
  logic mode_i = 1'b0;
  logic rx_i = 1'b1;
  logic busy_o, done_o, err_o;
  logic [CW-1:0] divisor_o;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  int n_done = 0;
  int n_err = 0;
  logic [CW-1:0] model_div = '0;

  always #2 clk_i = ~clk_i;

  uart_baud_detect u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm_i), .mode_i(mode_i),
    .rx_i(rx_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .divisor_o(divisor_o)
  );

  always @(negedge clk_i) begin
    cycles++;
    if (done_o) n_done++;
    if (err_o)  n_err++;
    if (cycles > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_meas(input bit m, input int a, input int b);
    return m ? a + b : a;
  endfunction

  function automatic bit exp_bad(input int meas);
    return (meas < 16) || (meas >= CMAX);
  endfunction

  function automatic int exp_div(input bit m, input int meas);
    return m ? (meas + 1) >> 1 : meas;
  endfunction

  // low phase a, high phase b, then a low tail and idle; poke disturbs mid-measurement
  task automatic run(input bit m, input int a, input int b, input bit poke, input string req);
    int meas;
    bit bad;
    @(negedge clk_i);
    n_done = 0; n_err = 0;
    arm_i = 1'b1; mode_i = m;
    @(negedge clk_i);
    arm_i = 1'b0;
    check("R8 busy after arm", busy_o, 1);
    repeat (3) @(negedge clk_i);
    rx_i = 1'b0;
    for (int i = 0; i < a; i++) begin
      if (poke && i == a / 2) begin
        arm_i = 1'b1; mode_i = ~m;
      end else begin
        arm_i = 1'b0;
      end
      @(negedge clk_i);
    end
    arm_i = 1'b0;
    rx_i = 1'b1;
    repeat (b) @(negedge clk_i);
    rx_i = 1'b0;
    repeat (6) @(negedge clk_i);
    rx_i = 1'b1;
    repeat (4) @(negedge clk_i);
    rx_i = 1'b0;
    repeat (20) @(negedge clk_i);
    rx_i = 1'b1;
    repeat (8) @(negedge clk_i);
    meas = exp_meas(m, a, b);
    bad  = exp_bad(meas);
    if (!bad) model_div = CW'(exp_div(m, meas));
    check({req, " done count"}, n_done, bad ? 0 : 1);
    check({req, " err count"}, n_err, bad ? 1 : 0);
    check({req, " divisor"}, int'(divisor_o), int'(model_div));
    check("R7 idle after result", busy_o, 0);
  endtask

  initial begin
    int a, b;
    bit m;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    check("R1 busy in reset", busy_o, 0);
    check("R1 done in reset", done_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 err after reset", err_o, 0);
    check("R1 divisor after reset", int'(divisor_o), 0);

    run(1'b0, 40, 25, 1'b0, "R2 mode0 basic");
    run(1'b1, 40, 25, 1'b0, "R3 mode1 odd sum");
    run(1'b1, 30, 30, 1'b0, "R3 mode1 even sum");
    run(1'b0, 16, 20, 1'b0, "R5 floor exact");
    run(1'b0, 15, 20, 1'b0, "R5 below floor");
    run(1'b1, 8, 7, 1'b0, "R5 mode1 below floor");
    run(1'b0, CMAX - 1, 20, 1'b0, "R6 ceiling minus one");
    run(1'b0, CMAX, 20, 1'b0, "R6 ceiling reached");
    run(1'b1, 4000, 200, 1'b0, "R6 mode1 overflow");
    run(1'b1, 50, 33, 1'b1, "R4 R8 poke mode1");
    run(1'b0, 50, 33, 1'b1, "R4 R8 poke mode0");

    for (int k = 0; k < 24; k++) begin
      m = 1'($urandom_range(1, 0));
      a = $urandom_range(300, 10);
      b = $urandom_range(300, 10);
      run(m, a, b, 1'($urandom_range(1, 0)), m ? "R3 random" : "R2 random");
    end

    // R7: edges with no arm give no result
    n_done = 0; n_err = 0;
    rx_i = 1'b0; repeat (40) @(negedge clk_i);
    rx_i = 1'b1; repeat (40) @(negedge clk_i);
    check("R7 no result unarmed", n_done + n_err, 0);
    check("R9 divisor kept unarmed", int'(divisor_o), int'(model_div));

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule